// File: doc/BRIEF.md
# NAND Read-Retry Parameter Sequencer

This block produces the bus-cycle sequences that a multi-level-cell NAND device needs for read retry. It does not drive NAND pins. Each cycle it wants goes to a lower physical layer as a request that carries a cycle type, a byte, a page and a length. The block then waits for that layer to accept the request.

There are two operations, chosen when the block starts:

- **Apply.** This puts the device into one retry mode. The block enters the vendor parameter mode and writes one table value to each of the eight vendor registers. It then commits the settings. The values come from an external table, which the block reads through a combinational read port.
- **Fetch.** This reads the factory retry table out of the device's one-time-programmable area and then puts the device back into normal operation. The bytes that are read are decoded elsewhere, and the result comes back on a verdict input. If the verdict is a failure, the block runs the whole fetch again using the second page layout.

Top module: `nand_rr_seq`

## Requirements
- R1: An apply issues these cycles in order: a command cycle with byte 0x36, then one address cycle and one data-out cycle per register, then a command cycle with byte 0x16. The cycle type codes are command=0, address=1, data-out=2, reset=3 and page read=4.
- R2: The register addresses are sent in this fixed order: 0xCC, 0xBF, 0xAA, 0xAB, 0xCD, 0xAD, 0xAE, 0xAF.
- R3: The data byte written to register i is the table entry at index mode*NREG+i. The mode index is captured when the operation starts.
- R4: A fetch opens with these cycles in order: reset, command 0x36, address 0x38, data 0x52, command 0x16. Commands 0x17, 0x04 and 0x19 follow, in that order.
- R5: On the first attempt, the fetch then issues a page read of page 0x21F with a length of 784 bytes.
- R6: After the page read, the fetch restores the device with these cycles in order: reset, command 0x36, address 0x38, data 0x00, command 0x16. It ends with a page read of page 0 with length 0.
- R7: After a fetch, the block waits for the verdict. A good verdict ends the operation without an error. A failed verdict on the first attempt makes the block repeat the full fetch with page 0x200 and length 528. A failed verdict on the second attempt ends the operation with the error flag raised.
- R8: The block advances by exactly one cycle per ready response. While ready is low, the request stays valid and does not change.
- R9: If the lower layer responds with an error, the sequence stops at once and no further requests are issued. The done pulse is raised together with the error flag.
- R10: A start request that arrives while the block is busy has no effect on the sequence that is running.
- R11: After reset the block is idle, with no request valid and with done and error both low. The done pulse lasts exactly one cycle, and the block is idle when it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, accepted only when the block is idle |
| op_fetch | input | 1 | Operation select: 0 = apply a mode, 1 = fetch the table |
| mode_in | input | MODE_W | Retry mode index for an apply |
| tbl_addr | output | MODE_W+IDX_W | Read address into the value table |
| tbl_data | input | 8 | Table value at tbl_addr, same cycle |
| cyc_valid | output | 1 | A cycle request is presented |
| cyc_type | output | 3 | Cycle type code |
| cyc_byte | output | 8 | Command, address or data byte |
| cyc_page | output | PAGE_W | Page for a page read |
| cyc_len | output | LEN_W | Byte count for a page read |
| cyc_ready | input | 1 | Lower layer has completed the presented cycle |
| cyc_err | input | 1 | The completed cycle failed, qualified by cyc_ready |
| dec_valid | input | 1 | Verdict on the fetched table is present |
| dec_ok | input | 1 | Verdict: the table was decoded correctly |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when an operation ends |
| err | output | 1 | Raised together with done when the operation failed |

## Verification
The embedded assertions check the handshake rules on every cycle:

- a stalled request stays valid and does not change;
- done lasts exactly one cycle, and the block is idle when it rises;
- an error always comes together with done;
- no request is presented while the block is idle;
- a start request has no effect while the block is busy.

Only the bench scenarios can show that the cycle contents are right. These include the command bytes, the register order, the table indexing for several modes, the two page layouts, the retry after a failed verdict, and the point at which an error response stops a sequence.

// File: rtl/nand_rr_seq.sv
module nand_rr_seq #(
  parameter int NREG   = 8,
  parameter int MODE_W = 3,
  parameter int PAGE_W = 16,
  parameter int LEN_W  = 16,
  parameter logic [PAGE_W-1:0] PAGE_A = 16'h021F,
  parameter logic [PAGE_W-1:0] PAGE_B = 16'h0200,
  parameter logic [LEN_W-1:0]  LEN_A  = 16'd784,
  parameter logic [LEN_W-1:0]  LEN_B  = 16'd528,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int TBL_W = MODE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_fetch,
  input  logic [MODE_W-1:0] mode_in,
  output logic [TBL_W-1:0]  tbl_addr,
  input  logic [7:0]        tbl_data,
  output logic              cyc_valid,
  output logic [2:0]        cyc_type,
  output logic [7:0]        cyc_byte,
  output logic [PAGE_W-1:0] cyc_page,
  output logic [LEN_W-1:0]  cyc_len,
  input  logic              cyc_ready,
  input  logic              cyc_err,
  input  logic              dec_valid,
  input  logic              dec_ok,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int APPLY_LAST = 2 * NREG + 1;
  localparam int FETCH_LAST = 14;
  localparam int MAX_LAST   = (APPLY_LAST > FETCH_LAST) ? APPLY_LAST : FETCH_LAST;
  localparam int STEP_W     = $clog2(MAX_LAST + 1);

  localparam logic [2:0] T_CMD = 3'd0, T_ADDR = 3'd1, T_DOUT = 3'd2,
                         T_RST = 3'd3, T_READ = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_VERD} state_t;

  state_t              state;
  logic [STEP_W-1:0]   step;
  logic                op_q, alt;
  logic [MODE_W-1:0]   mode_q;
  logic [STEP_W-1:0]   sm1;
  logic [IDX_W-1:0]    ridx;
  logic                last;

  function automatic logic [7:0] reg_addr(input logic [IDX_W-1:0] i);
    case (int'(i))
      0: return 8'hCC;
      1: return 8'hBF;
      2: return 8'hAA;
      3: return 8'hAB;
      4: return 8'hCD;
      5: return 8'hAD;
      6: return 8'hAE;
      default: return 8'hAF;
    endcase
  endfunction

  assign sm1       = step - 1'b1;
  assign ridx      = IDX_W'(sm1 >> 1);
  assign tbl_addr  = TBL_W'(mode_q) * TBL_W'(NREG) + TBL_W'(ridx);
  assign cyc_valid = (state == S_RUN);
  assign busy      = (state != S_IDLE);
  assign last      = op_q ? (step == STEP_W'(FETCH_LAST)) : (step == STEP_W'(APPLY_LAST));

  always_comb begin
    cyc_type = T_CMD;
    cyc_byte = 8'h00;
    cyc_page = '0;
    cyc_len  = '0;
    if (!op_q) begin
      if (step == '0)                        cyc_byte = 8'h36;
      else if (step == STEP_W'(APPLY_LAST))  cyc_byte = 8'h16;
      else if (step[0]) begin cyc_type = T_ADDR; cyc_byte = reg_addr(ridx); end
      else              begin cyc_type = T_DOUT; cyc_byte = tbl_data;       end
    end else begin
      case (int'(step))
        0, 9:   cyc_type = T_RST;
        1, 10:  cyc_byte = 8'h36;
        2, 11:  begin cyc_type = T_ADDR; cyc_byte = 8'h38; end
        3:      begin cyc_type = T_DOUT; cyc_byte = 8'h52; end
        12:     cyc_type = T_DOUT;
        4, 13:  cyc_byte = 8'h16;
        5:      cyc_byte = 8'h17;
        6:      cyc_byte = 8'h04;
        7:      cyc_byte = 8'h19;
        8: begin
          cyc_type = T_READ;
          cyc_page = alt ? PAGE_B : PAGE_A;
          cyc_len  = alt ? LEN_B  : LEN_A;
        end
        default: cyc_type = T_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      step   <= '0;
      op_q   <= 1'b0;
      alt    <= 1'b0;
      mode_q <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          op_q   <= op_fetch;
          mode_q <= mode_in;
          alt    <= 1'b0;
          step   <= '0;
          state  <= S_RUN;
        end
        S_RUN: if (cyc_ready) begin
          if (cyc_err) begin
            state <= S_IDLE; done <= 1'b1; err <= 1'b1;
          end else if (last) begin
            if (op_q) state <= S_VERD;
            else begin state <= S_IDLE; done <= 1'b1; end
          end else
            step <= step + 1'b1;
        end
        S_VERD: if (dec_valid) begin
          if (dec_ok) begin
            state <= S_IDLE; done <= 1'b1;
          end else if (!alt) begin
            alt <= 1'b1; step <= '0; state <= S_RUN;
          end else begin
            state <= S_IDLE; done <= 1'b1; err <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && !cyc_ready |=> cyc_valid && $stable(cyc_type) && $stable(cyc_byte)
                                && $stable(cyc_page) && $stable(cyc_len));

  p_err_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !cyc_valid);

  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !cyc_ready && !dec_valid |=> busy && !done);

  p_valid_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> busy);
endmodule

// File: tb/nand_rr_seq_test.sv
`timescale 1ns/1ps
module nand_rr_seq_test;
  logic clk = 0, rst_n = 0, start = 0, op_fetch = 0;
  logic [2:0] mode_in = 0;
  logic [5:0] tbl_addr;
  logic [7:0] tbl_data;
  logic cyc_valid, cyc_ready = 0, cyc_err = 0, dec_valid = 0, dec_ok = 0;
  logic [2:0] cyc_type;
  logic [7:0] cyc_byte;
  logic [15:0] cyc_page, cyc_len;
  logic busy, done, err;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] tv(input logic [5:0] a);
    return 8'((int'(a) * 29 + 7) & 8'hFF);
  endfunction
  assign tbl_data = tv(tbl_addr);

  nand_rr_seq uut (.clk(clk), .rst_n(rst_n), .start(start), .op_fetch(op_fetch),
    .mode_in(mode_in), .tbl_addr(tbl_addr), .tbl_data(tbl_data), .cyc_valid(cyc_valid),
    .cyc_type(cyc_type), .cyc_byte(cyc_byte), .cyc_page(cyc_page), .cyc_len(cyc_len),
    .cyc_ready(cyc_ready), .cyc_err(cyc_err), .dec_valid(dec_valid), .dec_ok(dec_ok),
    .busy(busy), .done(done), .err(err));

  localparam logic [7:0] REGS [8] = '{8'hCC, 8'hBF, 8'hAA, 8'hAB, 8'hCD, 8'hAD, 8'hAE, 8'hAF};
  // fetch cycles {type, byte}; page/len of the two reads set separately (R4, R5, R6)
  localparam logic [10:0] FSEQ [15] = '{
    {3'd3,8'h00},{3'd0,8'h36},{3'd1,8'h38},{3'd2,8'h52},{3'd0,8'h16},
    {3'd0,8'h17},{3'd0,8'h04},{3'd0,8'h19},{3'd4,8'h00},
    {3'd3,8'h00},{3'd0,8'h36},{3'd1,8'h38},{3'd2,8'h00},{3'd0,8'h16},{3'd4,8'h00}};

  typedef struct packed {
    logic op; logic [2:0] m; logic [3:0] stall; logic [7:0] erri;
    logic ok1; logic ok2; logic [7:0] n; logic e;
  } scen_t;
  localparam scen_t SC [6] = '{
    '{1'b0, 3'd0, 4'd0, 8'd255, 1'b1, 1'b1, 8'd18, 1'b0},
    '{1'b0, 3'd5, 4'd2, 8'd255, 1'b1, 1'b1, 8'd18, 1'b0},
    '{1'b0, 3'd7, 4'd1, 8'd255, 1'b1, 1'b1, 8'd18, 1'b0},
    '{1'b1, 3'd0, 4'd0, 8'd255, 1'b1, 1'b1, 8'd15, 1'b0},
    '{1'b1, 3'd0, 4'd1, 8'd255, 1'b0, 1'b1, 8'd30, 1'b0},
    '{1'b1, 3'd0, 4'd0, 8'd255, 1'b0, 1'b0, 8'd30, 1'b1}};

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_at(input bit op, input int m, input int k,
      output logic [2:0] et, output logic [7:0] eb, output logic [15:0] ep, output logic [15:0] el);
    ep = 0; el = 0;
    if (!op) begin
      if (k == 0) begin et = 0; eb = 8'h36; end
      else if (k == 17) begin et = 0; eb = 8'h16; end
      else if (k % 2 == 1) begin et = 1; eb = REGS[(k-1)/2]; end
      else begin et = 2; eb = tv(6'(m * 8 + (k-1)/2)); end
    end else begin
      int s = k % 15;
      et = FSEQ[s][10:8]; eb = FSEQ[s][7:0];
      if (s == 8) begin ep = (k >= 15) ? 16'h200 : 16'h21F; el = (k >= 15) ? 16'd528 : 16'd784; end
    end
  endtask

  task automatic run(input string req, input bit op, input int m, input int stall, input int erri,
      input bit ok1, input bit ok2, input bit restart, input int exp_n, input bit exp_e);
    int ncyc = 0, waitc = 0, att = 0, it = 0;
    bit got_done = 0, got_err = 0;
    logic [2:0] et; logic [7:0] eb; logic [15:0] ep, el;
    logic [7:0] pb = 0;
    @(negedge clk);
    start = 1; op_fetch = op; mode_in = 3'(m);
    while (it < 400) begin
      @(negedge clk);
      it++;
      start = 0; cyc_ready = 0; cyc_err = 0; dec_valid = 0;
      if (restart && it == 3) begin start = 1; op_fetch = ~op; mode_in = ~3'(m); end
      if (done) begin got_done = 1; got_err = err; break; end
      if (cyc_valid) begin
        if (waitc > 0) chk("R8", "stalled byte stable", cyc_byte, pb);
        if (waitc < stall) begin waitc++; pb = cyc_byte; end
        else begin
          expect_at(op, m, ncyc, et, eb, ep, el);
          chk(req, $sformatf("type@%0d", ncyc), cyc_type, et);
          chk(req, $sformatf("byte@%0d", ncyc), cyc_byte, eb);
          if (op) begin
            chk(req, $sformatf("page@%0d", ncyc), cyc_page, ep);
            chk(req, $sformatf("len@%0d", ncyc), cyc_len, el);
          end
          cyc_ready = 1; cyc_err = (ncyc == erri);
          ncyc++; waitc = 0;
        end
      end else if (busy) begin
        dec_valid = 1; dec_ok = (att == 0) ? ok1 : ok2; att++;
      end
    end
    chk(req, "done seen", got_done, 1);
    chk(req, "cycle count", ncyc, exp_n);
    chk(req, "error flag", got_err, exp_e);
    @(negedge clk);
    chk("R11", "done one cycle", done, 0);
    chk("R11", "idle after done", {busy, cyc_valid}, 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++; tests++;
    $display("FAIL watchdog expired: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "reset idle", {busy, cyc_valid, done, err}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R11", "idle after release", {busy, cyc_valid}, 0);
    // R1 R2 R3 apply modes, R4 R5 R6 R7 fetch layouts and verdicts
    for (int i = 0; i < 6; i++)
      run(SC[i].op ? "R7" : "R3", SC[i].op, SC[i].m, SC[i].stall, SC[i].erri,
          SC[i].ok1, SC[i].ok2, 1'b0, SC[i].n, SC[i].e);
    // R9 error response aborts in apply and fetch
    run("R9", 0, 3, 0, 4, 1, 1, 0, 5, 1);
    run("R9", 1, 0, 1, 8, 1, 1, 0, 9, 1);
    // R10 start during busy ignored: sequence matches original mode and op
    run("R10", 0, 2, 0, 255, 1, 1, 1, 18, 0);
    run("R10", 1, 0, 0, 255, 1, 1, 1, 15, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule